// File: doc/BRIEF.md
# Posted Column Command Delay Stage

This block sits on the device side of a memory command path. It takes a decoded read or write command, which may arrive as early as the cycle right after the row it targets was opened. It holds the command for a programmed additive latency of 0 to 6 clock cycles. It then hands the command to the internal column logic. The command carries its kind, its bank, its column address and its auto-precharge flag, and all four leave the block unchanged.

The controller can send column commands back to back without waiting out the row-to-column delay itself. The additive latency moves the internal issue far enough out that this delay is met. The block also keeps, for each bank, a count of the cycles since that bank was last activated. It raises an error flag in any cycle where a released command reaches its bank too soon.

Top module: `posted_cas_stage`

## Requirements
- R1: A synchronous active-high reset discards every command in flight. After reset, `int_valid` and `rcd_err` are 0, and a command accepted before reset never appears.
- R2: With an active latency of 0, a command on the inputs appears on the internal outputs in the same cycle, with identical fields.
- R3: With an active latency of k (1 to 6), a command accepted in cycle n produces `int_valid` = 1 in cycle n+k only. The outputs show no internal command in cycles n+1 to n+k-1.
- R4: Each released command carries the kind, bank, column and auto-precharge flag it was accepted with. Kind 0 means read and kind 1 means write. Commands to different banks accepted in consecutive cycles come out in consecutive cycles, in the same order.
- R5: A new `al_cfg` value becomes the active latency only in a cycle where no command is in flight and none is presented. A command already in flight keeps the latency it was accepted under.
- R6: An `al_cfg` value of 7 acts as a latency of 6.
- R7: Call the cycle after an activate of bank b cycle 1 for bank b. A command to bank b released in a cycle whose count is below TRCD (default 3) raises `rcd_err` in that same cycle. With TRCD 3, a read accepted one cycle after the activate gives no error at latency 2 and gives an error at latency 1.
- R8: A command released to a bank that has not been activated since reset never raises `rcd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| al_cfg | input | 3 | Requested additive latency (7 treated as 6) |
| act_valid | input | 1 | Row activate seen this cycle |
| act_bank | input | 3 | Bank being activated |
| cmd_valid | input | 1 | Column command accepted this cycle |
| cmd_kind | input | 1 | 0 = read, 1 = write |
| cmd_bank | input | 3 | Column command bank |
| cmd_col | input | 10 | Column address |
| cmd_ap | input | 1 | Auto-precharge flag |
| int_valid | output | 1 | Internal column command strobe |
| int_kind | output | 1 | Released command kind |
| int_bank | output | 3 | Released command bank |
| int_col | output | 10 | Released column address |
| int_ap | output | 1 | Released auto-precharge flag |
| rcd_err | output | 1 | Released command violates row-to-column delay |

## Verification
The bench builds the block with its defaults: a 6-stage delay line, 8 banks and a row-to-column delay of 3. These values put every legal latency within reach, along with the clamped value 7. They also make the stated example reachable: an activate, a read one cycle later, no error at latency 2 and an error at latency 1. Because the delay line is only six deep, the bench can also drain it quickly. This lets it show that a latency change is held back until the line is empty, and that a reset drops a command in flight.

// File: rtl/pcas_pkg.sv
package pcas_pkg;

    localparam int BANK_W = 3;
    localparam int COL_W  = 10;

    typedef enum logic {
        CK_READ  = 1'b0,
        CK_WRITE = 1'b1
    } col_kind_e;

    typedef struct packed {
        col_kind_e          kind;
        logic [BANK_W-1:0]  bank;
        logic [COL_W-1:0]   col;
        logic               ap;
    } col_cmd_t;

    function automatic logic [2:0] clamp_al(input logic [2:0] req, input logic [2:0] max_al);
        return (req > max_al) ? max_al : req;
    endfunction

endpackage

// File: rtl/pcas_delay_line.sv
module pcas_delay_line
    import pcas_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  col_cmd_t         in_cmd,
    input  logic [SEL_W-1:0] tap,
    output logic             out_valid,
    output col_cmd_t         out_cmd,
    output logic             busy
);

    logic     vld [1:DEPTH];
    col_cmd_t stg [1:DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i <= DEPTH; i++) vld[i] <= 1'b0;
        end else begin
            vld[1] <= in_valid;
            for (int i = 2; i <= DEPTH; i++) vld[i] <= vld[i-1];
        end
    end

    always_ff @(posedge clk) begin
        stg[1] <= in_cmd;
        for (int i = 2; i <= DEPTH; i++) stg[i] <= stg[i-1];
    end

    always_comb begin
        out_valid = in_valid;
        out_cmd   = in_cmd;
        for (int i = 1; i <= DEPTH; i++) begin
            if (tap == SEL_W'(i)) begin
                out_valid = vld[i];
                out_cmd   = stg[i];
            end
        end
    end

    always_comb begin
        busy = 1'b0;
        for (int i = 1; i <= DEPTH; i++) busy = busy | vld[i];
    end

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> !busy);

endmodule

// File: rtl/pcas_al_ctrl.sv
module pcas_al_ctrl
    import pcas_pkg::*;
#(
    parameter int AL_MAX = 6,
    parameter int AL_W   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AL_W-1:0] al_cfg,
    input  logic            busy,
    input  logic            cmd_valid,
    output logic [AL_W-1:0] al_q
);

    localparam logic [AL_W-1:0] AL_TOP = AL_W'(AL_MAX);

    always_ff @(posedge clk) begin
        if (rst)
            al_q <= '0;
        else if (!busy && !cmd_valid)
            al_q <= (al_cfg > AL_TOP) ? AL_TOP : al_cfg;
    end

    a_r5_hold_when_busy: assert property (@(posedge clk) disable iff (rst)
        (busy || cmd_valid) |=> $stable(al_q));
    a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
        al_q <= AL_TOP);

endmodule

// File: rtl/pcas_rcd_guard.sv
module pcas_rcd_guard
    import pcas_pkg::*;
#(
    parameter int TRCD      = 3,
    parameter int NUM_BANKS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_valid,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              chk_valid,
    input  logic [BANK_W-1:0] chk_bank,
    output logic              err
);

    localparam int AGE_W = $clog2(TRCD + 1);
    localparam logic [AGE_W-1:0] SAT = AGE_W'(TRCD);

    logic [AGE_W-1:0] age [NUM_BANKS];

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            always_ff @(posedge clk) begin
                if (rst)
                    age[b] <= SAT;
                else if (act_valid && act_bank == BANK_W'(b))
                    age[b] <= AGE_W'(1);
                else if (age[b] != SAT)
                    age[b] <= age[b] + AGE_W'(1);
            end
        end
    endgenerate

    assign err = chk_valid && (age[chk_bank] < SAT);

    generate
        if (TRCD > 1) begin : g_chk
            a_r7_early_flag: assert property (@(posedge clk) disable iff (rst)
                act_valid |=> ((chk_valid && chk_bank == $past(act_bank)) -> err));
        end
    endgenerate

endmodule

// File: rtl/posted_cas_stage.sv
module posted_cas_stage
    import pcas_pkg::*;
#(
    parameter int AL_MAX = 6,
    parameter int TRCD   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          al_cfg,
    input  logic                act_valid,
    input  logic [BANK_W-1:0]   act_bank,
    input  logic                cmd_valid,
    input  logic                cmd_kind,
    input  logic [BANK_W-1:0]   cmd_bank,
    input  logic [COL_W-1:0]    cmd_col,
    input  logic                cmd_ap,
    output logic                int_valid,
    output logic                int_kind,
    output logic [BANK_W-1:0]   int_bank,
    output logic [COL_W-1:0]    int_col,
    output logic                int_ap,
    output logic                rcd_err
);

    localparam int AL_W      = 3;
    localparam int NUM_BANKS = 1 << BANK_W;

    col_cmd_t        cmd_in, cmd_out;
    logic            busy;
    logic [AL_W-1:0] al_q;

    assign cmd_in = '{kind: col_kind_e'(cmd_kind), bank: cmd_bank, col: cmd_col, ap: cmd_ap};

    pcas_al_ctrl #(.AL_MAX(AL_MAX), .AL_W(AL_W)) u_ctrl (
        .clk(clk), .rst(rst), .al_cfg(al_cfg), .busy(busy),
        .cmd_valid(cmd_valid), .al_q(al_q)
    );

    pcas_delay_line #(.DEPTH(AL_MAX), .SEL_W(AL_W)) u_line (
        .clk(clk), .rst(rst), .in_valid(cmd_valid), .in_cmd(cmd_in),
        .tap(al_q), .out_valid(int_valid), .out_cmd(cmd_out), .busy(busy)
    );

    pcas_rcd_guard #(.TRCD(TRCD), .NUM_BANKS(NUM_BANKS)) u_guard (
        .clk(clk), .rst(rst), .act_valid(act_valid), .act_bank(act_bank),
        .chk_valid(int_valid), .chk_bank(cmd_out.bank), .err(rcd_err)
    );

    assign int_kind = cmd_out.kind;
    assign int_bank = cmd_out.bank;
    assign int_col  = cmd_out.col;
    assign int_ap   = cmd_out.ap;

    a_r2_zero_pass: assert property (@(posedge clk) disable iff (rst)
        (al_q == '0) |-> (int_valid == cmd_valid));
    a_r3_single_delay: assert property (@(posedge clk) disable iff (rst)
        (al_q == AL_W'(1) && cmd_valid) |=> int_valid);
    a_r4_fields_kept: assert property (@(posedge clk) disable iff (rst)
        (al_q == AL_W'(1) && cmd_valid) |=> (cmd_out == $past(cmd_in)));
    a_r7_err_with_issue: assert property (@(posedge clk) disable iff (rst)
        rcd_err |-> int_valid);

endmodule

// File: tb/posted_cas_stage_bench.sv
module posted_cas_stage_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] al_cfg = 3'd0;
    logic       act_valid = 1'b0;
    logic [2:0] act_bank = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_kind = 1'b0;
    logic [2:0] cmd_bank = '0;
    logic [9:0] cmd_col = '0;
    logic       cmd_ap = 1'b0;
    logic       int_valid, int_kind, int_ap, rcd_err;
    logic [2:0] int_bank;
    logic [9:0] int_col;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    posted_cas_stage u_posted_cas_stage (
        .clk(clk), .rst(rst), .al_cfg(al_cfg),
        .act_valid(act_valid), .act_bank(act_bank),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .int_valid(int_valid), .int_kind(int_kind), .int_bank(int_bank),
        .int_col(int_col), .int_ap(int_ap), .rcd_err(rcd_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic a, input logic [2:0] ab, input logic cv,
                       input logic k, input logic [2:0] b, input logic [9:0] c, input logic ap);
        @(negedge clk);
        act_valid = a; act_bank = ab;
        cmd_valid = cv; cmd_kind = k; cmd_bank = b; cmd_col = c; cmd_ap = ap;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic chk_out(input string req, input logic k, input logic [2:0] b,
                           input logic [9:0] c, input logic ap);
        chk({req, " valid"}, 32'(int_valid), 32'd1);
        chk({req, " kind"}, 32'(int_kind), 32'(k));
        chk({req, " bank"}, 32'(int_bank), 32'(b));
        chk({req, " col"}, 32'(int_col), 32'(c));
        chk({req, " ap"}, 32'(int_ap), 32'(ap));
    endtask

    task automatic set_al(input logic [2:0] v);
        al_cfg = v;
        idle(8);
    endtask

    task automatic t_reset;
        al_cfg = 3'd4;
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(3);
        chk("R1 idle valid", 32'(int_valid), 32'd0);
        chk("R1 idle err", 32'(rcd_err), 32'd0);
        cyc(0, 0, 1, 1, 3'd1, 10'h0AA, 1);
        idle(1);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        for (int j = 0; j < 7; j++) begin
            idle(1);
            chk("R1 dropped in flight", 32'(int_valid), 32'd0);
        end
    endtask

    task automatic t_latency(input int k);
        set_al(3'(k));
        cyc(0, 0, 1, 0, 3'd2, 10'(10'h155 + k), 0);
        for (int j = 0; j <= k; j++) begin
            if (j > 0) idle(1);
            if (j == k) begin
                if (k == 0) chk_out("R2 passthrough", 0, 3'd2, 10'(10'h155 + k), 0);
                else        chk_out("R3 delay", 0, 3'd2, 10'(10'h155 + k), 0);
            end else begin
                chk("R3 early quiet", 32'(int_valid), 32'd0);
            end
        end
        idle(1);
        if (k > 0) chk("R3 single pulse", 32'(int_valid), 32'd0);
    endtask

    task automatic t_back_to_back;
        logic [2:0] bk [3];
        logic [9:0] cl [3];
        logic       kd [3];
        logic       apf [3];
        bk = '{3'd1, 3'd2, 3'd3};
        cl = '{10'h011, 10'h222, 10'h3F3};
        kd = '{1'b0, 1'b1, 1'b0};
        apf = '{1'b1, 1'b0, 1'b1};
        set_al(3'd3);
        for (int j = 0; j < 6; j++) begin
            if (j < 3) cyc(0, 0, 1, kd[j], bk[j], cl[j], apf[j]);
            else       idle(1);
            if (j >= 3) chk_out("R4 ordered fields", kd[j-3], bk[j-3], cl[j-3], apf[j-3]);
        end
    endtask

    task automatic t_al_change_busy;
        set_al(3'd4);
        cyc(0, 0, 1, 1, 3'd5, 10'h123, 1);
        al_cfg = 3'd1;
        for (int j = 1; j <= 4; j++) begin
            idle(1);
            if (j < 4) chk("R5 old latency kept", 32'(int_valid), 32'd0);
            else       chk_out("R5 old latency kept", 1, 3'd5, 10'h123, 1);
        end
        idle(5);
        cyc(0, 0, 1, 0, 3'd5, 10'h124, 0);
        chk("R5 new latency quiet", 32'(int_valid), 32'd0);
        idle(1);
        chk_out("R5 new latency", 0, 3'd5, 10'h124, 0);
    endtask

    task automatic t_clamp;
        set_al(3'd7);
        cyc(0, 0, 1, 0, 3'd2, 10'h077, 0);
        for (int j = 1; j <= 6; j++) begin
            idle(1);
            if (j < 6) chk("R6 clamp quiet", 32'(int_valid), 32'd0);
            else       chk_out("R6 clamp at 6", 0, 3'd2, 10'h077, 0);
        end
    endtask

    task automatic t_rcd;
        set_al(3'd2);
        cyc(1, 3'd5, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 3'd5, 10'h050, 0);
        idle(1);
        chk("R7 not yet issued", 32'(int_valid), 32'd0);
        idle(1);
        chk_out("R7 al2 issue", 0, 3'd5, 10'h050, 0);
        chk("R7 al2 no error", 32'(rcd_err), 32'd0);
        set_al(3'd1);
        cyc(1, 3'd4, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 3'd4, 10'h060, 0);
        idle(1);
        chk_out("R7 al1 issue", 1, 3'd4, 10'h060, 0);
        chk("R7 al1 error", 32'(rcd_err), 32'd1);
        idle(1);
        chk("R7 error clears", 32'(rcd_err), 32'd0);
        cyc(0, 0, 1, 0, 3'd7, 10'h070, 0);
        idle(1);
        chk("R8 fresh bank valid", 32'(int_valid), 32'd1);
        chk("R8 fresh bank no error", 32'(rcd_err), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        for (int k = 0; k <= 6; k++) t_latency(k);
        t_back_to_back();
        t_al_change_busy();
        t_clamp();
        t_rcd();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule